// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block collects 64 interrupt sources and drives two request lines towards a processor: a normal request and a fast request. Each source keeps a pending bit, an enable bit, a type bit that routes it to the fast or the normal line, and a 4-bit priority. A 5-bit threshold gates the normal line, so that only sources above the running priority level interrupt the processor. One threshold value lets every source through.

Software sees the block as a bank of 32-bit words, addressed by word index. Reading the normal vector word returns the best pending normal source and acknowledges it in the same access by clearing its pending bit. Reading the fast vector word acknowledges every pending fast source at once. Software can also write the pending bits directly, and it can enable or disable one source by writing its number. A source request input sets pending bits from hardware.

Top module: `vpic_top`

Word map (index on `bus_addr`): 0 threshold, 1 control, 2/3 pending low/high, 4/5 enable low/high, 6/7 type low/high, 8 enable-by-number, 9 disable-by-number, 10 normal vector, 11 fast vector, 12/13 masked normal view low/high, 14/15 masked fast view low/high, 16..23 priority slots. "Low" holds sources 0..31 and "high" holds sources 32..63.

## Requirements
- R1: Pending, enable and type are each reachable as a low word (sources 0..31, bit n = source n) and a high word (bit n = source 32+n). A write to one word leaves the other word unchanged, and a read returns the stored value.
- R2: `irq_fast` is high exactly when at least one source is pending, enabled and has its type bit set (type 1 = fast).
- R3: Let "candidates" be the sources that are pending, enabled and of normal type. If there are no candidates, or if the threshold equals 31, `irq_norm` is high exactly when there is a candidate. Otherwise `irq_norm` is high only if some candidate has a priority strictly greater than the threshold.
- R4: The priority of source i is the nibble at bits 4*(i%8)+3..4*(i%8) of priority word i/8. Priority word w is stored at slot index 16+(7-w), so slot 16 holds sources 56..63 and slot 23 holds sources 0..7. The slots read back what was written.
- R5: A write to word 8 sets the enable bit numbered wdata[5:0]. A write to word 9 clears the enable bit numbered wdata[5:0]. The upper data bits are ignored.
- R6: A read of word 10 returns the candidate with the highest priority, with the source number in bits 31:16 and its priority in bits 15:0. The clock edge that ends the read clears that source's pending bit.
- R7: On a priority tie the higher-numbered source wins the word 10 read. With no candidate the read returns 0xFFFFFFFF and changes nothing.
- R8: A read of word 11 clears every pending, enabled, fast-type source and returns the highest such source number in bits 31:16 with bits 15:0 zero. With none, the read returns 0xFFFFFFFF.
- R9: After reset, pending, enable, type, every priority word and the control word are zero, the threshold is 31, and both outputs are low.
- R10: The control word keeps only bits 3:0. Bit 0 is the flag-clear enable and bit 1 is the flag. When a write has bit 0 set, a 1 written to bit 1 clears the flag instead of storing it.
- R11: Words 12..15 read pending & enable & ~type (normal view) and pending & enable & type (fast view), each split into low and high halves. Writes to these words change nothing.
- R12: A high `src_req[i]` sets pending bit i at the next edge. It takes precedence over an acknowledge or a software clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req | input | 64 | Per-source request, sets pending bits |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle; triggers acknowledge side effects |
| bus_addr | input | 5 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the current state and address |
| irq_norm | output | 1 | Normal interrupt request |
| irq_fast | output | 1 | Fast interrupt request |

## Verification
The bench places a single prioritised source at each of the 64 positions in turn. A design that indexed the priority slots forward, or used the wrong nibble, would report the wrong source number or priority. Equal-priority sets check that the tie goes to the higher number: a scan that accepted equal priorities would pick the lower number. A sweep of all 32 threshold values against priorities 0, 7 and 15 catches an off-by-one in the comparison or a missing pass-all case for threshold 31. Other stimuli cover write-1-to-clear of the control flag, writes to the read-only views, and fast acknowledges that leave normal pending bits untouched. These catch a block that stores the flag, lets view writes through, or clears too much.

// File: rtl/vpic_pkg.sv
// Shared constants for the vectored prioritized interrupt controller.
// Word indices are on a 5-bit word address. The priority slot block must stay
// at the end because its ordering is reversed against the priority words.
package vpic_pkg;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] A_MASK    = 5'd0;
    localparam logic [ADDR_W-1:0] A_CTRL    = 5'd1;
    localparam logic [ADDR_W-1:0] A_PEND_LO = 5'd2;
    localparam logic [ADDR_W-1:0] A_PEND_HI = 5'd3;
    localparam logic [ADDR_W-1:0] A_EN_LO   = 5'd4;
    localparam logic [ADDR_W-1:0] A_EN_HI   = 5'd5;
    localparam logic [ADDR_W-1:0] A_TYP_LO  = 5'd6;
    localparam logic [ADDR_W-1:0] A_TYP_HI  = 5'd7;
    localparam logic [ADDR_W-1:0] A_EN_NUM  = 5'd8;
    localparam logic [ADDR_W-1:0] A_DIS_NUM = 5'd9;
    localparam logic [ADDR_W-1:0] A_NVEC    = 5'd10;
    localparam logic [ADDR_W-1:0] A_FVEC    = 5'd11;
    localparam logic [ADDR_W-1:0] A_NV_LO   = 5'd12;
    localparam logic [ADDR_W-1:0] A_NV_HI   = 5'd13;
    localparam logic [ADDR_W-1:0] A_FV_LO   = 5'd14;
    localparam logic [ADDR_W-1:0] A_FV_HI   = 5'd15;
    localparam logic [ADDR_W-1:0] A_PRIO0   = 5'd16;

    localparam int          CTRL_W     = 4;
    localparam logic [3:0]  CTRL_DEF   = 4'hF;
    localparam int          CB_FLAG_EN = 0;
    localparam int          CB_FLAG    = 1;

    localparam logic [31:0] NO_VECTOR  = 32'hFFFF_FFFF;
endpackage

// File: rtl/vpic_norm_arb.sv
// Normal-source arbiter.
// Scans the candidate vector from the top index downwards and keeps a source
// only when its priority is strictly above the best found so far, so that equal
// priorities resolve to the higher-numbered source.
// Assumes: prio_flat holds PRIO_W bits per source, source i at i*PRIO_W.
module vpic_norm_arb #(
    parameter int N_SRC  = 64,
    parameter int PRIO_W = 4,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0]        cand,
    input  logic [N_SRC*PRIO_W-1:0] prio_flat,
    output logic                    win_valid,
    output logic [IDX_W-1:0]        win_idx,
    output logic [PRIO_W-1:0]       win_prio
);
    // Downward scan with strict-greater replacement.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_prio  = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (cand[i] && (!win_valid || prio_flat[i*PRIO_W +: PRIO_W] > win_prio)) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                win_prio  = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/vpic_norm_gate.sv
// Threshold gate for the normal request line.
// With no candidate, or with the threshold at its all-ones value, the line
// follows "any candidate". Otherwise a candidate must have a priority strictly
// above the threshold.
// Assumes: MASK_W > PRIO_W, so a priority never equals the pass-all value.
module vpic_norm_gate #(
    parameter int N_SRC  = 64,
    parameter int PRIO_W = 4,
    parameter int MASK_W = 5
) (
    input  logic [N_SRC-1:0]        cand,
    input  logic [N_SRC*PRIO_W-1:0] prio_flat,
    input  logic [MASK_W-1:0]       mask,
    output logic                    irq
);
    localparam logic [MASK_W-1:0] PASS_ALL = '1;

    logic [N_SRC-1:0] above;

    for (genvar i = 0; i < N_SRC; i++) begin : g_cmp
        // Per-source comparison against the threshold.
        assign above[i] = cand[i] && (MASK_W'(prio_flat[i*PRIO_W +: PRIO_W]) > mask);
    end

    // Pass-all or empty case follows the candidate OR; else the comparison OR.
    always_comb begin
        if (cand == '0 || mask == PASS_ALL) irq = |cand;
        else                                 irq = |above;
    end
endmodule

// File: rtl/vpic_fast_pick.sv
// Fast-source summary: reports whether any fast candidate exists and the
// highest-numbered one, used as the fast vector read value.
module vpic_fast_pick #(
    parameter int N_SRC = 64,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0] cand,
    output logic             any,
    output logic [IDX_W-1:0] top_idx
);
    // Upward scan; the last hit is the highest index.
    always_comb begin
        any     = 1'b0;
        top_idx = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (cand[i]) begin
                any     = 1'b1;
                top_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/vpic_top.sv
// Vectored prioritized interrupt controller, top level.
// Holds the register file (pending, enable, type, priorities, threshold,
// control), decodes word accesses and applies the read side effects of the
// two vector words.
// Assumes: N_SRC = 64, so each per-source vector splits into two 32-bit halves.
// bus_rd and bus_wr are single-cycle strobes; bus_rdata is combinational.
module vpic_top
    import vpic_pkg::*;
#(
    parameter int N_SRC  = 64,
    parameter int PRIO_W = 4,
    parameter int MASK_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_req,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_norm,
    output logic              irq_fast
);
    localparam int IDX_W    = $clog2(N_SRC);
    localparam int HALF     = N_SRC / 2;
    localparam int PER_WORD = DATA_W / PRIO_W;
    localparam int N_PW     = N_SRC / PER_WORD;
    localparam int HW       = DATA_W / 2;

    logic [N_SRC-1:0]             pend_q, pend_d;
    logic [N_SRC-1:0]             en_q, en_d;
    logic [N_SRC-1:0]             typ_q, typ_d;
    logic [N_PW-1:0][DATA_W-1:0]  prio_q, prio_d;
    logic [MASK_W-1:0]            mask_q, mask_d;
    logic [CTRL_W-1:0]            ctrl_q, ctrl_d;

    logic [N_SRC*PRIO_W-1:0] prio_flat;
    logic [N_SRC-1:0]        cand_n, cand_f;
    logic                    win_valid;
    logic [IDX_W-1:0]        win_idx;
    logic [PRIO_W-1:0]       win_prio;
    logic                    f_any;
    logic [IDX_W-1:0]        f_idx;
    logic                    rd_nvec, rd_fvec;

    // Unpack the priority words into a per-source flat vector.
    for (genvar i = 0; i < N_SRC; i++) begin : g_prio
        assign prio_flat[i*PRIO_W +: PRIO_W] =
            prio_q[i / PER_WORD][PRIO_W*(i % PER_WORD) +: PRIO_W];
    end

    assign cand_n  = pend_q & en_q & ~typ_q;
    assign cand_f  = pend_q & en_q & typ_q;
    assign rd_nvec = bus_rd && (bus_addr == A_NVEC);
    assign rd_fvec = bus_rd && (bus_addr == A_FVEC);

    vpic_norm_arb #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_arb (
        .cand      (cand_n),
        .prio_flat (prio_flat),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_prio  (win_prio)
    );

    vpic_norm_gate #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .MASK_W(MASK_W)) u_gate (
        .cand      (cand_n),
        .prio_flat (prio_flat),
        .mask      (mask_q),
        .irq       (irq_norm)
    );

    vpic_fast_pick #(.N_SRC(N_SRC)) u_fast (
        .cand    (cand_f),
        .any     (f_any),
        .top_idx (f_idx)
    );

    assign irq_fast = f_any;

    // Read multiplexer over the word map.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_MASK:    bus_rdata = DATA_W'(mask_q);
            A_CTRL:    bus_rdata = DATA_W'(ctrl_q);
            A_PEND_LO: bus_rdata = pend_q[HALF-1:0];
            A_PEND_HI: bus_rdata = pend_q[N_SRC-1:HALF];
            A_EN_LO:   bus_rdata = en_q[HALF-1:0];
            A_EN_HI:   bus_rdata = en_q[N_SRC-1:HALF];
            A_TYP_LO:  bus_rdata = typ_q[HALF-1:0];
            A_TYP_HI:  bus_rdata = typ_q[N_SRC-1:HALF];
            A_NVEC:    bus_rdata = win_valid ? {HW'(win_idx), HW'(win_prio)} : NO_VECTOR;
            A_FVEC:    bus_rdata = f_any ? {HW'(f_idx), HW'(0)} : NO_VECTOR;
            A_NV_LO:   bus_rdata = cand_n[HALF-1:0];
            A_NV_HI:   bus_rdata = cand_n[N_SRC-1:HALF];
            A_FV_LO:   bus_rdata = cand_f[HALF-1:0];
            A_FV_HI:   bus_rdata = cand_f[N_SRC-1:HALF];
            default: begin
                for (int w = 0; w < N_PW; w++) begin
                    if (bus_addr == A_PRIO0 + ADDR_W'(N_PW - 1 - w)) bus_rdata = prio_q[w];
                end
            end
        endcase
    end

    // Pending next state: software write, then acknowledges, then requests.
    always_comb begin
        pend_d = pend_q;
        if (bus_wr && bus_addr == A_PEND_LO) pend_d[HALF-1:0]     = bus_wdata;
        if (bus_wr && bus_addr == A_PEND_HI) pend_d[N_SRC-1:HALF] = bus_wdata;
        if (rd_nvec && win_valid)            pend_d[win_idx]      = 1'b0;
        if (rd_fvec)                         pend_d               = pend_d & ~cand_f;
        pend_d = pend_d | src_req;
    end

    // Enable next state: halves and set/clear by number.
    always_comb begin
        en_d = en_q;
        if (bus_wr) begin
            case (bus_addr)
                A_EN_LO:   en_d[HALF-1:0]     = bus_wdata;
                A_EN_HI:   en_d[N_SRC-1:HALF] = bus_wdata;
                A_EN_NUM:  en_d[bus_wdata[IDX_W-1:0]] = 1'b1;
                A_DIS_NUM: en_d[bus_wdata[IDX_W-1:0]] = 1'b0;
                default:   ;
            endcase
        end
    end

    // Type, threshold, control and priority next state.
    always_comb begin
        typ_d  = typ_q;
        mask_d = mask_q;
        ctrl_d = ctrl_q;
        prio_d = prio_q;
        if (bus_wr) begin
            case (bus_addr)
                A_TYP_LO: typ_d[HALF-1:0]     = bus_wdata;
                A_TYP_HI: typ_d[N_SRC-1:HALF] = bus_wdata;
                A_MASK:   mask_d = bus_wdata[MASK_W-1:0];
                A_CTRL: begin
                    ctrl_d = bus_wdata[CTRL_W-1:0] & CTRL_DEF;
                    if (bus_wdata[CB_FLAG_EN] && bus_wdata[CB_FLAG]) ctrl_d[CB_FLAG] = 1'b0;
                end
                default: begin
                    for (int w = 0; w < N_PW; w++) begin
                        if (bus_addr == A_PRIO0 + ADDR_W'(N_PW - 1 - w)) prio_d[w] = bus_wdata;
                    end
                end
            endcase
        end
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            en_q   <= '0;
            typ_q  <= '0;
            prio_q <= '0;
            mask_q <= '1;
            ctrl_q <= '0;
        end else begin
            pend_q <= pend_d;
            en_q   <= en_d;
            typ_q  <= typ_d;
            prio_q <= prio_d;
            mask_q <= mask_d;
            ctrl_q <= ctrl_d;
        end
    end
endmodule

// File: rtl/vpic_checker.sv
// Property checker for vpic_top, attached by bind below.
// Watches the bus, the request lines and selected internal state.
module vpic_checker
    import vpic_pkg::*;
#(
    parameter int N_SRC  = 64,
    parameter int PRIO_W = 4,
    parameter int MASK_W = 5,
    parameter int CTRL_W_P = 4,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_SRC-1:0]  src_req,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              irq_norm,
    input logic              irq_fast,
    input logic [N_SRC-1:0]  pend_q,
    input logic [N_SRC-1:0]  en_q,
    input logic [MASK_W-1:0] mask_q,
    input logic [CTRL_W_P-1:0] ctrl_q,
    input logic              win_valid,
    input logic [PRIO_W-1:0] win_prio
);
    logic [IDX_W-1:0] ack_idx_q;

    // Remember the source number presented on the bus each cycle.
    always_ff @(posedge clk) ack_idx_q <= bus_rdata[16 +: IDX_W];

    p_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pend_q == '0 && en_q == '0 && mask_q == '1 && ctrl_q == '0));

    p_en_num_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_EN_NUM) |=> en_q[$past(bus_wdata[IDX_W-1:0])]);

    p_nvec_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_NVEC && bus_rdata != NO_VECTOR && !bus_wr && src_req == '0)
        |=> !pend_q[ack_idx_q]);

    p_nvec_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_NVEC && bus_rdata == NO_VECTOR) |-> !irq_norm);

    p_norm_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_norm && mask_q != '1) |-> (win_valid && MASK_W'(win_prio) > mask_q));

    p_fvec_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_FVEC && !bus_wr && src_req == '0) |=> !irq_fast);

    p_fvec_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_FVEC && !irq_fast) |-> bus_rdata == NO_VECTOR);
endmodule

bind vpic_top vpic_checker #(
    .N_SRC(N_SRC), .PRIO_W(PRIO_W), .MASK_W(MASK_W), .CTRL_W_P(CTRL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_req   (src_req),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_norm  (irq_norm),
    .irq_fast  (irq_fast),
    .pend_q    (pend_q),
    .en_q      (en_q),
    .mask_q    (mask_q),
    .ctrl_q    (ctrl_q),
    .win_valid (win_valid),
    .win_prio  (win_prio)
);

// File: tb/vpic_top_test.sv
`timescale 1ns/1ps
// Self-checking bench for vpic_top: sweeps source positions, thresholds and
// enable numbers, with expected values worked out arithmetically.
module vpic_top_test;
    import vpic_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_req = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_norm, irq_fast;

    int n_cmp = 0;
    int n_bad = 0;

    vpic_top uut (
        .clk(clk), .rst_n(rst_n), .src_req(src_req),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_norm(irq_norm), .irq_fast(irq_fast)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    // Slot index for priority word w (reversed order).
    function automatic logic [4:0] slot(input int w);
        return A_PRIO0 + 5'(7 - w);
    endfunction

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [63:0] exp_en;
        logic [63:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R9 reset state
        rd(A_MASK, d);    chk("R9 mask", d, 32'h1F);
        rd(A_CTRL, d);    chk("R9 ctrl", d, 0);
        rd(A_PEND_LO, d); chk("R9 pend", d, 0);
        rd(A_EN_HI, d);   chk("R9 en", d, 0);
        rd(A_TYP_LO, d);  chk("R9 typ", d, 0);
        rd(slot(3), d);   chk("R9 prio", d, 0);
        chk("R9 outputs", {30'd0, irq_norm, irq_fast}, 0);

        // R10 control flag write-1-to-clear
        wr(A_CTRL, 32'hFF);  rd(A_CTRL, d); chk("R10 ff", d, 32'hD);
        wr(A_CTRL, 32'h2);   rd(A_CTRL, d); chk("R10 store flag", d, 32'h2);
        wr(A_CTRL, 32'h3);   rd(A_CTRL, d); chk("R10 clear flag", d, 32'h1);
        wr(A_CTRL, 32'h0);

        // R1 half independence
        wr(A_EN_LO, 32'hA5A5_0F0F); wr(A_EN_HI, 32'h1234_5678);
        wr(A_EN_LO, 32'h0000_0001);
        rd(A_EN_HI, d); chk("R1 en hi kept", d, 32'h1234_5678);
        rd(A_EN_LO, d); chk("R1 en lo", d, 32'h1);
        wr(A_TYP_HI, 32'hDEAD_BEEF); wr(A_TYP_LO, 32'h5);
        rd(A_TYP_HI, d); chk("R1 typ hi", d, 32'hDEAD_BEEF);
        rd(A_TYP_LO, d); chk("R1 typ lo", d, 32'h5);
        wr(A_PEND_HI, 32'h8000_0001); wr(A_PEND_LO, 32'h7);
        rd(A_PEND_HI, d); chk("R1 pend hi", d, 32'h8000_0001);
        wr(A_PEND_LO, 0); wr(A_PEND_HI, 0); wr(A_TYP_LO, 0); wr(A_TYP_HI, 0);

        // R5 enable/disable by number, upper data bits ignored
        wr(A_EN_LO, 0); wr(A_EN_HI, 0); exp_en = '0;
        for (int i = 0; i < 64; i++) begin
            wr(A_EN_NUM, 32'(i) | ((i % 2 == 1) ? 32'h40 : 32'hFFC0));
            exp_en[i] = 1'b1;
            rd(A_EN_LO, d); chk("R5 set lo", d, exp_en[31:0]);
            rd(A_EN_HI, d); chk("R5 set hi", d, exp_en[63:32]);
        end
        for (int i = 0; i < 64; i += 2) begin
            wr(A_DIS_NUM, 32'(i) | 32'h100);
            exp_en[i] = 1'b0;
        end
        rd(A_EN_LO, d); chk("R5 clear lo", d, exp_en[31:0]);
        rd(A_EN_HI, d); chk("R5 clear hi", d, exp_en[63:32]);

        // R4 / R6 single prioritised source at every position
        wr(A_EN_LO, '1); wr(A_EN_HI, '1);
        for (int i = 0; i < 64; i++) begin
            wr(A_PEND_LO, '1); wr(A_PEND_HI, '1);
            wr(slot(i / 8), 32'h9 << (4 * (i % 8)));
            rd(A_NVEC, d); chk("R4 R6 vector", d, {16'(i), 16'h9});
            v = '1; v[i] = 1'b0;
            rd((i < 32) ? A_PEND_LO : A_PEND_HI, d);
            chk("R6 ack", d, (i < 32) ? v[31:0] : v[63:32]);
            if (i == 13) begin
                rd(slot(1), d); chk("R4 readback", d, 32'h0090_0000);
            end
            wr(slot(i / 8), 0);
        end

        // R7 ties and empty
        wr(A_PEND_LO, '1); wr(A_PEND_HI, '1);
        rd(A_NVEC, d); chk("R7 tie top", d, 32'h003F_0000);
        rd(A_NVEC, d); chk("R7 tie next", d, 32'h003E_0000);
        wr(slot(1), 32'h0000_0055);
        rd(A_NVEC, d); chk("R7 tie prio5", d, 32'h0009_0005);
        rd(A_NVEC, d); chk("R7 tie prio5 next", d, 32'h0008_0005);
        wr(slot(1), 0);
        wr(A_PEND_LO, 0); wr(A_PEND_HI, 0);
        rd(A_NVEC, d); chk("R7 empty", d, 32'hFFFF_FFFF);
        chk("R3 no candidate", {31'd0, irq_norm}, 0);

        // R3 threshold sweep, source 20 alone
        wr(A_PEND_LO, 32'h0010_0000);
        for (int k = 0; k < 3; k++) begin
            int p;
            p = (k == 0) ? 0 : ((k == 1) ? 7 : 15);
            wr(slot(2), 32'(p) << 16);
            for (int m = 0; m < 32; m++) begin
                wr(A_MASK, 32'(m) | 32'hE0);
                chk("R3 threshold", {31'd0, irq_norm}, {31'd0, (m == 31) || (p > m)});
            end
        end
        wr(slot(2), 0); wr(A_MASK, 32'h1F); wr(A_PEND_LO, 0);

        // R2 / R8 / R11 fast path and views
        wr(A_TYP_LO, 32'h0000_0110); wr(A_TYP_HI, 32'h8000_0000);
        wr(A_PEND_LO, 32'h10);
        wr(A_DIS_NUM, 4);
        chk("R2 disabled fast", {31'd0, irq_fast}, 0);
        wr(A_EN_NUM, 4 + 64);
        chk("R2 enabled fast", {31'd0, irq_fast}, 1);
        wr(A_PEND_LO, '1); wr(A_PEND_HI, '1);
        rd(A_FV_LO, d); chk("R11 fast lo", d, 32'h0000_0110);
        rd(A_FV_HI, d); chk("R11 fast hi", d, 32'h8000_0000);
        rd(A_NV_LO, d); chk("R11 norm lo", d, ~32'h0000_0110);
        wr(A_NV_LO, 0); wr(A_FV_HI, 0);
        rd(A_NV_LO, d); chk("R11 write ignored", d, ~32'h0000_0110);
        rd(A_PEND_LO, d); chk("R11 pend kept", d, '1);
        rd(A_FVEC, d); chk("R8 fast vector", d, 32'h003F_0000);
        chk("R2 fast cleared", {31'd0, irq_fast}, 0);
        rd(A_PEND_LO, d); chk("R8 normals kept lo", d, ~32'h0000_0110);
        rd(A_PEND_HI, d); chk("R8 normals kept hi", d, 32'h7FFF_FFFF);
        rd(A_FVEC, d); chk("R8 fast empty", d, 32'hFFFF_FFFF);
        chk("R3 normal up", {31'd0, irq_norm}, 1);

        // R12 hardware request
        wr(A_PEND_LO, 0); wr(A_PEND_HI, 0); wr(A_TYP_LO, 0); wr(A_TYP_HI, 0);
        chk("R12 idle", {31'd0, irq_norm}, 0);
        @(negedge clk); src_req[33] = 1'b1;
        @(negedge clk); src_req[33] = 1'b0;
        rd(A_PEND_HI, d); chk("R12 pending set", d, 32'h2);
        chk("R12 normal out", {31'd0, irq_norm}, 1);
        @(negedge clk); src_req[33] = 1'b1; bus_rd = 1'b1; bus_addr = A_NVEC;
        @(negedge clk); src_req[33] = 1'b0; bus_rd = 1'b0;
        rd(A_PEND_HI, d); chk("R12 request beats ack", d, 32'h2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule